// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block is the slave side of a 256-byte serial EEPROM that sits on an I2C-style two-wire bus. It watches already-synchronized copies of the clock and data lines and answers through a single pull-low enable for the open-drain data line. It recognises start and stop conditions and a fixed 7-bit device address. The lowest bit of the address byte chooses the direction: 0 writes and 1 reads. A write frame carries a word address and then data bytes. The data bytes gather in a four-byte page buffer and reach the internal register array only when the frame closes with a stop.

A committed write opens an internal write cycle whose length is a parameter in clock cycles. For that whole time the slave is deaf: it acknowledges nothing and drives nothing, so a host can poll for completion by repeating the device address until it is acknowledged. Reads return data MSB first. A read either continues from the internal address pointer or follows an address-only write and a repeated start. It keeps streaming bytes for as long as the host acknowledges them.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the SDA pull-low enable is deasserted, every array byte reads 0xFF and the address pointer is 0x00.
- R2: The slave acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits equal DEV_ADDR; any other address byte gets no acknowledge and the rest of the frame is ignored.
- R3: In a write frame the word address byte and every data byte are acknowledged on their ninth clock.
- R4: Consecutive data bytes land at word addresses whose two low bits count up by one and wrap from 3 to 0, while the upper six bits keep the value of the word address; a fifth or later byte overwrites the earlier one in the same slot.
- R5: A stop that ends a write frame holding at least one data byte commits the page buffer and starts an internal write cycle of WRITE_CYCLES clocks; a frame that ends after only the word address commits nothing and starts no write cycle.
- R6: During the internal write cycle the slave never pulls SDA low, acknowledges no address, and the bus traffic it sees changes no stored byte.
- R7: A random read (address-only write, repeated start, address byte with bit 0 = 1) returns first the byte at the given word address.
- R8: In a read the pointer advances over all eight bits and wraps from 0xFF to 0x00; a host acknowledge (SDA low on the ninth clock) yields the next byte, and no acknowledge (SDA high) ends the read.
- R9: A read that starts without a word address returns the byte one past the last byte written or read.
- R10: A repeated start inside a write frame discards buffered data bytes, and a stop that arrives after two or more bits of a data byte aborts the frame; neither commits data nor starts a write cycle.
- R11: The slave changes its SDA drive only while SCL is low, and it releases SDA for the host's ninth clock of every read byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line level |
| sda_i | input | 1 | Synchronized bus data line level |
| sda_pull_o | output | 1 | When high, the slave pulls the data line low |

## Verification
Four things are checked on every clock. The slave stays silent while a write cycle runs. That cycle never lasts longer than its parameter and only ever begins on a stop. The SDA drive moves only while SCL is low, and each stored data byte advances the low pointer bits without carrying into the page bits. What cannot be seen one cycle at a time is left to the bench scenarios, which compare against a behavioural model of the array and pointer. These cover in-page wrap after six bytes, the 0xFF to 0x00 read wrap, current-address continuity, the rule that address-only or aborted frames commit nothing, and writes sent during a write cycle that leave the array unchanged.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_MACK,
        ST_BUSY
    } ctrl_state_e;

    // Events derived from one sampled bus step
    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    function automatic logic dev_hit(input logic [7:0] addr_byte,
                                     input logic [6:0] dev);
        return addr_byte[7:1] == dev;
    endfunction

endpackage

// File: rtl/twi_bus_events.sv
module twi_bus_events
    import twi_eeprom_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt_o.scl_rise = ~scl_q & scl_i;
        evt_o.scl_fall = scl_q & ~scl_i;
        evt_o.start    = scl_q & scl_i & sda_q & ~sda_i;
        evt_o.stop     = scl_q & scl_i & ~sda_q & sda_i;
        evt_o.sda      = sda_i;
    end
endmodule

// File: rtl/twi_page_buffer.sv
module twi_page_buffer #(
    parameter int PAGE_W = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clear_i,
    input  logic                           wr_i,
    input  logic [PAGE_W-1:0]              off_i,
    input  logic [7:0]                     data_i,
    output logic [(1<<PAGE_W)-1:0][7:0]    data_o,
    output logic [(1<<PAGE_W)-1:0]         mask_o
);
    localparam int SLOTS = 1 << PAGE_W;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam logic [PAGE_W-1:0] SLOT_ID = PAGE_W'(s);
        always_ff @(posedge clk) begin
            if (rst || clear_i) begin
                data_o[s] <= 8'h00;
                mask_o[s] <= 1'b0;
            end else if (wr_i && off_i == SLOT_ID) begin
                data_o[s] <= data_i;
                mask_o[s] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]       base_i,
    input  logic [(1<<PAGE_W)-1:0][7:0]    page_data_i,
    input  logic [(1<<PAGE_W)-1:0]         page_mask_i,
    input  logic [ADDR_W-1:0]              rd_addr_i,
    output logic [7:0]                     rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][7:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [ADDR_W-1:0] CELL_A = ADDR_W'(g);
        logic [7:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= 8'hFF;
            end else if (commit_i && base_i == CELL_A[ADDR_W-1:PAGE_W]
                         && page_mask_i[CELL_A[PAGE_W-1:0]]) begin
                q <= page_data_i[CELL_A[PAGE_W-1:0]];
            end
        end
        assign cells[g] = q;
    end

    assign rd_data_o = cells[rd_addr_i];
endmodule

// File: rtl/twi_eeprom_ctrl.sv
module twi_eeprom_ctrl
    import twi_eeprom_pkg::*;
#(
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_W       = 2,
    parameter logic [6:0] DEV_ADDR     = 7'h50,
    parameter int         WRITE_CYCLES = 1250000
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_evt_t            evt_i,
    input  logic [7:0]          rd_data_i,
    output logic                sda_pull_o,
    output logic                busy_o,
    output logic [ADDR_W-1:0]   ptr_o,
    output logic                buf_wr_o,
    output logic [PAGE_W-1:0]   buf_off_o,
    output logic [7:0]          buf_data_o,
    output logic                buf_clear_o,
    output logic                commit_o
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    ctrl_state_e        state;
    logic [3:0]         bit_cnt;
    logic [7:0]         shreg;
    logic [7:0]         tx;
    logic [ADDR_W-1:0]  ptr;
    logic [CNT_W-1:0]   cnt;
    logic               pull;
    logic               has_data;
    logic               rw_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            tx          <= '0;
            ptr         <= '0;
            cnt         <= '0;
            pull        <= 1'b0;
            has_data    <= 1'b0;
            rw_rd       <= 1'b0;
            buf_wr_o    <= 1'b0;
            buf_off_o   <= '0;
            buf_data_o  <= '0;
            buf_clear_o <= 1'b0;
            commit_o    <= 1'b0;
        end else begin
            buf_wr_o    <= 1'b0;
            buf_clear_o <= 1'b0;
            commit_o    <= 1'b0;
            if (state == ST_BUSY) begin
                // deaf for the whole write cycle
                pull <= 1'b0;
                if (cnt == CNT_W'(WRITE_CYCLES - 1)) begin
                    cnt   <= '0;
                    state <= ST_IDLE;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (evt_i.start) begin
                state       <= ST_DEV;
                bit_cnt     <= '0;
                pull        <= 1'b0;
                buf_clear_o <= 1'b1;
                has_data    <= 1'b0;
            end else if (evt_i.stop) begin
                pull     <= 1'b0;
                bit_cnt  <= '0;
                has_data <= 1'b0;
                // a stop at a byte boundary sees at most one clock of the next byte
                if (state == ST_WDATA && bit_cnt <= 4'd1 && has_data) begin
                    commit_o <= 1'b1;
                    cnt      <= '0;
                    state    <= ST_BUSY;
                end else begin
                    buf_clear_o <= 1'b1;
                    state       <= ST_IDLE;
                end
            end else begin
                case (state)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (evt_i.scl_rise) begin
                            shreg   <= {shreg[6:0], evt_i.sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (evt_i.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                if (dev_hit(shreg, DEV_ADDR)) begin
                                    pull  <= 1'b1;
                                    rw_rd <= shreg[0];
                                    state <= ST_DEV_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_WADDR) begin
                                ptr   <= ADDR_W'(shreg);
                                pull  <= 1'b1;
                                state <= ST_WADDR_ACK;
                            end else begin
                                buf_wr_o   <= 1'b1;
                                buf_off_o  <= ptr[PAGE_W-1:0];
                                buf_data_o <= shreg;
                                ptr        <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                                has_data   <= 1'b1;
                                pull       <= 1'b1;
                                state      <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (evt_i.scl_fall) begin
                            if (rw_rd) begin
                                tx      <= rd_data_i;
                                pull    <= ~rd_data_i[7];
                                ptr     <= ptr + 1'b1;
                                bit_cnt <= '0;
                                state   <= ST_RDATA;
                            end else begin
                                pull  <= 1'b0;
                                state <= ST_WADDR;
                            end
                        end
                    end
                    ST_WADDR_ACK, ST_WDATA_ACK: begin
                        if (evt_i.scl_fall) begin
                            pull  <= 1'b0;
                            state <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (evt_i.scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (evt_i.scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                pull    <= 1'b0;
                                bit_cnt <= '0;
                                state   <= ST_MACK;
                            end else begin
                                pull <= ~tx[6];
                                tx   <= {tx[6:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt_i.scl_rise) begin
                            if (evt_i.sda) begin
                                state <= ST_IDLE;
                            end
                        end else if (evt_i.scl_fall) begin
                            tx      <= rd_data_i;
                            pull    <= ~rd_data_i[7];
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                            state   <= ST_RDATA;
                        end
                    end
                    default: begin
                        pull <= 1'b0;
                    end
                endcase
            end
        end
    end

    assign sda_pull_o = pull;
    assign busy_o     = (state == ST_BUSY);
    assign ptr_o      = ptr;
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_eeprom_pkg::*;
#(
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_W       = 2,
    parameter logic [6:0] DEV_ADDR     = 7'h50,
    parameter int         WRITE_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);
    localparam int SLOTS = 1 << PAGE_W;

    bus_evt_t                 evt;
    logic [7:0]               rd_data;
    logic                     ctrl_busy;
    logic [ADDR_W-1:0]        ctrl_ptr;
    logic                     buf_wr;
    logic [PAGE_W-1:0]        buf_off;
    logic [7:0]               buf_data;
    logic                     buf_clear;
    logic                     commit;
    logic [SLOTS-1:0][7:0]    page_data;
    logic [SLOTS-1:0]         page_mask;

    twi_bus_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    twi_eeprom_ctrl #(
        .ADDR_W       (ADDR_W),
        .PAGE_W       (PAGE_W),
        .DEV_ADDR     (DEV_ADDR),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .evt_i       (evt),
        .rd_data_i   (rd_data),
        .sda_pull_o  (sda_pull_o),
        .busy_o      (ctrl_busy),
        .ptr_o       (ctrl_ptr),
        .buf_wr_o    (buf_wr),
        .buf_off_o   (buf_off),
        .buf_data_o  (buf_data),
        .buf_clear_o (buf_clear),
        .commit_o    (commit)
    );

    // buffer clears on the same edge the array takes its contents
    twi_page_buffer #(.PAGE_W(PAGE_W)) u_page (
        .clk     (clk),
        .rst     (rst),
        .clear_i (buf_clear | commit),
        .wr_i    (buf_wr),
        .off_i   (buf_off),
        .data_i  (buf_data),
        .data_o  (page_data),
        .mask_o  (page_mask)
    );

    twi_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
        .clk         (clk),
        .rst         (rst),
        .commit_i    (commit),
        .base_i      (ctrl_ptr[ADDR_W-1:PAGE_W]),
        .page_data_i (page_data),
        .page_mask_i (page_mask),
        .rd_addr_i   (ctrl_ptr),
        .rd_data_o   (rd_data)
    );
endmodule

// File: rtl/twi_eeprom_slave_checker.sv
module twi_eeprom_slave_checker #(
    parameter int ADDR_W       = 8,
    parameter int PAGE_W       = 2,
    parameter int WRITE_CYCLES = 1250000
) (
    input logic              clk,
    input logic              rst,
    input logic              scl_i,
    input logic              sda_pull,
    input logic              busy,
    input logic              evt_start,
    input logic              evt_stop,
    input logic              buf_wr,
    input logic [ADDR_W-1:0] ptr
);
    localparam int RUN_W = $clog2(WRITE_CYCLES + 2) + 1;

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else busy_run <= '0;
    end

    // R6: silent while the write cycle runs
    p_quiet_busy_r6: assert property (@(posedge clk) disable iff (rst)
        busy |-> !sda_pull);

    // R5: write cycle never exceeds its length
    p_cycle_len_r5: assert property (@(posedge clk) disable iff (rst)
        busy_run <= RUN_W'(WRITE_CYCLES));

    // R5: write cycle only begins on a stop
    p_busy_on_stop_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(evt_stop));

    // R4: a stored byte never carries into the page bits
    p_page_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

    // R4: low bits step by one per stored byte
    p_page_step_r4: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1));

    // R11: drive changes only while SCL is low
    p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pull) && !$past(evt_start || evt_stop)) |-> !scl_i);
endmodule

bind twi_eeprom_slave twi_eeprom_slave_checker #(
    .ADDR_W       (ADDR_W),
    .PAGE_W       (PAGE_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_checker (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_pull  (sda_pull_o),
    .busy      (ctrl_busy),
    .evt_start (evt.start),
    .evt_stop  (evt.stop),
    .buf_wr    (buf_wr),
    .ptr       (ctrl_ptr)
);

// File: tb/twi_eeprom_slave_bench.sv
module twi_eeprom_slave_bench;
    localparam int         WC  = 1000;
    localparam int         Q   = 4;
    localparam logic [6:0] DEV = 7'h50;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull;
    logic sda_bus;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int busy_from = -1;
    int busy_to = -1;
    logic [7:0] mdl_mem [256];
    logic [7:0] mdl_ptr;

    assign sda_bus = m_sda & ~sda_pull;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    twi_eeprom_slave #(.DEV_ADDR(DEV), .WRITE_CYCLES(WC)) u_twi_eeprom_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R6: per-clock silence inside the modelled write-cycle window
    always @(negedge clk) begin
        if (!rst && busy_from >= 0 && cyc >= busy_from && cyc <= busy_to)
            chk("R6 slave silent in write cycle", int'(sda_pull), 0);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop(output int at);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; at = cyc; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_bus; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic more);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        m_sda = ~more; tick(Q);
        m_scl = 1'b1; tick(Q);
        chk("R11 released on host ninth clock", int'(sda_pull), 0);
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] d [8]);
        logic ak;
        int at;
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        chk("R2 device address ack", int'(ak), 1);
        send_byte(a, ak);
        chk("R3 word address ack", int'(ak), 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ak);
            chk("R3 data byte ack", int'(ak), 1);
            mdl_mem[{a[7:2], 2'(a[1:0] + i)}] = d[i];
        end
        bus_stop(at);
        if (n > 0) begin
            mdl_ptr   = {a[7:2], 2'(a[1:0] + n)};
            busy_from = at + 3;
            busy_to   = at + WC - 3;
        end else begin
            mdl_ptr = a;
        end
    endtask

    task automatic wait_done();
        tick(WC + 20);
        busy_from = -1;
    endtask

    task automatic rd_random(input logic [7:0] a, input int n);
        logic ak;
        logic [7:0] d;
        int at;
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        chk("R7 address ack before read", int'(ak), 1);
        send_byte(a, ak);
        chk("R7 word address ack", int'(ak), 1);
        bus_start();
        send_byte({DEV, 1'b1}, ak);
        chk("R7 read address ack", int'(ak), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i < n - 1);
            chk(i == 0 ? "R7 random read data" : "R8 sequential read data",
                int'(d), int'(mdl_mem[8'(a + i)]));
        end
        bus_stop(at);
        mdl_ptr = 8'(a + n);
    endtask

    task automatic rd_current(input int n, input string req);
        logic ak;
        logic [7:0] d;
        int at;
        bus_start();
        send_byte({DEV, 1'b1}, ak);
        chk("R9 current read address ack", int'(ak), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(d, i < n - 1);
            chk(req, int'(d), int'(mdl_mem[8'(mdl_ptr + i)]));
        end
        bus_stop(at);
        mdl_ptr = 8'(mdl_ptr + n);
    endtask

    initial begin
        tick(200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic ak;
        logic [7:0] d;
        int at;
        for (int i = 0; i < 256; i++) mdl_mem[i] = 8'hFF;
        mdl_ptr = 8'h00;
        rst = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R1 SDA released after reset", int'(sda_pull), 0);
        rd_current(2, "R1 erased array from pointer zero");

        // byte write plus completion polling
        do_write(8'h10, 1, '{8'h3C, 0, 0, 0, 0, 0, 0, 0});
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        chk("R6 no ack during write cycle", int'(ak), 0);
        bus_stop(at);
        wait_done();
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        chk("R5 ack once write cycle ends", int'(ak), 1);
        bus_stop(at);
        rd_random(8'h10, 1);
        rd_current(1, "R9 byte after last read");

        // page wrap with six bytes
        do_write(8'h21, 6, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 0, 0});
        wait_done();
        rd_random(8'h20, 5);

        // full address wrap on read
        do_write(8'hFE, 2, '{8'hA1, 8'hA2, 0, 0, 0, 0, 0, 0});
        wait_done();
        do_write(8'h00, 1, '{8'hC3, 0, 0, 0, 0, 0, 0, 0});
        wait_done();
        rd_random(8'hFE, 3);
        rd_current(1, "R9 current read after wrap");

        // address-only write: no cycle
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        send_byte(8'h30, ak);
        bus_stop(at);
        bus_start();
        send_byte({DEV, 1'b1}, ak);
        chk("R5 address-only frame starts no cycle", int'(ak), 1);
        recv_byte(d, 1'b0);
        chk("R9 read at written pointer", int'(d), int'(mdl_mem[8'h30]));
        bus_stop(at);
        mdl_ptr = 8'h31;

        // foreign device address
        bus_start();
        send_byte({7'h53, 1'b0}, ak);
        chk("R2 foreign address not acked", int'(ak), 0);
        bus_stop(at);

        // traffic during a write cycle is ignored
        do_write(8'h40, 1, '{8'h11, 0, 0, 0, 0, 0, 0, 0});
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        chk("R6 address ignored in cycle", int'(ak), 0);
        send_byte(8'h40, ak);
        chk("R6 word address ignored in cycle", int'(ak), 0);
        send_byte(8'h99, ak);
        chk("R6 data ignored in cycle", int'(ak), 0);
        bus_stop(at);
        wait_done();
        rd_random(8'h40, 1);

        // repeated start discards buffered data
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        send_byte(8'h50, ak);
        send_byte(8'hAA, ak);
        chk("R3 data ack before abort", int'(ak), 1);
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        chk("R10 no cycle after restart abort", int'(ak), 1);
        bus_stop(at);
        rd_random(8'h50, 1);

        // stop mid-byte aborts
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        send_byte(8'h54, ak);
        send_byte(8'h77, ak);
        put_bit(1'b1);
        put_bit(1'b0);
        put_bit(1'b1);
        bus_stop(at);
        bus_start();
        send_byte({DEV, 1'b0}, ak);
        chk("R10 no cycle after mid-byte stop", int'(ak), 1);
        bus_stop(at);
        rd_random(8'h54, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule